// File: doc/BRIEF.md
# Interlaced Field Weaving Frame-Buffer Writer

This block sits between a video decoder and a frame buffer. It receives a 16-bit pixel stream along with four timing flags: pixel-valid, a horizontal line reference, a vertical field reference and a field-parity flag. For every valid pixel it issues one write to the buffer. Each write carries a row address, a column address and the pixel data. The row address interleaves the lines of the two interlaced fields so that the buffer ends up holding a single progressive frame.

The row address is formed from a line-within-field count shifted left by one, with the field parity in bit 0. Lines of odd fields therefore land on odd rows and lines of even fields land on even rows. Every line begins at column 0. Counting restarts with each field, so the buffer is rewritten over and over, one pixel per clock. A one-cycle completion pulse marks each finished frame, which is the end of an even field that followed a written odd field.

Top module: `field_weave_writer`

## Requirements
- R1: While rst_n is low and on the first edge after it, wrEn and frameDone are 0, and rowAddr, colAddr and wrData are 0.
- R2: A write happens only for a pixel sampled with pixValid high. wrEn is 1 in the cycle after such a pixel, wrData equals that pixel, and cycles without pixValid produce wrEn 0.
- R3: The first valid pixel of a line is written at column 0. This holds even when it arrives in the same cycle as the hRef rise. Each later valid pixel of the line takes the next column, and invalid cycles inside the line do not advance the column.
- R4: The column saturates at 1023 (all COL_W bits set). Extra pixels in the same line keep writing to column 1023.
- R5: The line count advances when hRef falls, but only if that line carried at least one valid pixel. A dropped line with no valid pixels uses no row.
- R6: The line count returns to 0 while vRef is high. The first written line of every field, and so of every new frame, goes to row 0 (even field) or row 1 (odd field).
- R7: The field parity is the value of oddFlag in the cycle vRef falls (1 = odd field, 0 = even field). rowAddr = 2 × line + parity, with the parity in bit 0.
- R8: frameDone pulses high for exactly one cycle. It does so in the cycle after a vRef rise that ends an even field, provided that even field wrote pixels and an odd field with written pixels came before it since the last pulse.
- R9: Changes on oddFlag at any time other than the vRef falling edge have no effect on the row addresses written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pixData | input | DATA_W (16) | Pixel from the decoder |
| pixValid | input | 1 | High when pixData holds a pixel to store |
| hRef | input | 1 | Horizontal reference, high for the span of a line |
| vRef | input | 1 | Vertical reference, high pulse at each field start |
| oddFlag | input | 1 | Field parity flag, sampled as vRef falls (1 = odd) |
| rowAddr | output | ROW_W (10) | Frame row of the write |
| colAddr | output | COL_W (10) | Column of the write |
| wrData | output | DATA_W (16) | Pixel data of the write |
| wrEn | output | 1 | Write strobe, one per stored pixel |
| frameDone | output | 1 | One-cycle pulse when a woven frame is complete |

## Verification
A stale or corrupted column counter shows up on colAddr in the very next write. Missing a line start, for example, produces a write that does not begin at column 0. A wrong line count or a wrong latched parity first appears on rowAddr at the next written line, and it stays wrong for the rest of that field. A fault in the odd-field bookkeeping shows up only at the next even-field boundary, as a missing or extra frameDone one cycle after the vRef rise. For that reason, the stimulus includes empty fields and repeated field orders.

// File: rtl/weave_pkg.sv
package weave_pkg;
  // Strobes from the control half to the address datapath.
  typedef struct packed {
    logic hStart;     // rising edge of hRef seen this cycle
    logic hEnd;       // falling edge of hRef seen this cycle
    logic fieldClr;   // vertical reference active: restart line count
    logic pixTake;    // store the pixel presented this cycle
    logic fieldOdd;   // parity of the field being written
  } weaveStrobes_t;
endpackage

// File: rtl/weave_ctrl.sv
module weave_ctrl
  import weave_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pixValid,
  input  logic          hRef,
  input  logic          vRef,
  input  logic          oddFlag,
  output weaveStrobes_t strobes,
  output logic          frameDone
);
  logic hRefPrev, vRefPrev;
  logic fieldOdd, oddDone, fieldHadPix;
  logic vRise, vFall, fieldOddNow;

  assign vRise       = vRef & ~vRefPrev;
  assign vFall       = ~vRef & vRefPrev;
  assign fieldOddNow = vFall ? oddFlag : fieldOdd;

  always_comb begin
    strobes.hStart   = hRef & ~hRefPrev;
    strobes.hEnd     = ~hRef & hRefPrev;
    strobes.fieldClr = vRef;
    strobes.pixTake  = pixValid;
    strobes.fieldOdd = fieldOddNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hRefPrev    <= 1'b0;
      vRefPrev    <= 1'b0;
      fieldOdd    <= 1'b0;
      oddDone     <= 1'b0;
      fieldHadPix <= 1'b0;
      frameDone   <= 1'b0;
    end else begin
      hRefPrev  <= hRef;
      vRefPrev  <= vRef;
      frameDone <= 1'b0;
      if (vFall) fieldOdd <= oddFlag;
      if (vRise) begin
        // the field that just ended decides the pairing state
        if (!fieldOdd && oddDone && fieldHadPix) begin
          frameDone <= 1'b1;
          oddDone   <= 1'b0;
        end else if (fieldOdd && fieldHadPix) begin
          oddDone <= 1'b1;
        end
        fieldHadPix <= 1'b0;
      end else if (pixValid) begin
        fieldHadPix <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/weave_dpath.sv
module weave_dpath
  import weave_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  weaveStrobes_t     strobes,
  input  logic [DATA_W-1:0] pixData,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn
);
  localparam int LINE_W = ROW_W - 1;
  localparam logic [COL_W-1:0]  COL_MAX  = {COL_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [COL_W-1:0]  colCnt, colNow;
  logic [LINE_W-1:0] lineCnt;
  logic              lineHadPix;

  assign colNow = strobes.hStart ? '0 : colCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colCnt     <= '0;
      lineCnt    <= '0;
      lineHadPix <= 1'b0;
      rowAddr    <= '0;
      colAddr    <= '0;
      wrData     <= '0;
      wrEn       <= 1'b0;
    end else begin
      wrEn <= strobes.pixTake;
      if (strobes.pixTake) begin
        wrData  <= pixData;
        colAddr <= colNow;
        rowAddr <= {lineCnt, strobes.fieldOdd};
        colCnt  <= (colNow == COL_MAX) ? COL_MAX : colNow + 1'b1;
      end else if (strobes.hStart) begin
        colCnt <= '0;
      end

      if (strobes.hStart)     lineHadPix <= strobes.pixTake;
      else if (strobes.hEnd)  lineHadPix <= 1'b0;
      else if (strobes.pixTake) lineHadPix <= 1'b1;

      if (strobes.fieldClr)
        lineCnt <= '0;
      else if (strobes.hEnd && lineHadPix && lineCnt != LINE_MAX)
        lineCnt <= lineCnt + 1'b1;
    end
  end
endmodule

// File: rtl/field_weave_writer.sv
module field_weave_writer
  import weave_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pixData,
  input  logic              pixValid,
  input  logic              hRef,
  input  logic              vRef,
  input  logic              oddFlag,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic              frameDone
);
  weaveStrobes_t strobes;

  weave_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixValid(pixValid), .hRef(hRef),
    .vRef(vRef), .oddFlag(oddFlag), .strobes(strobes), .frameDone(frameDone)
  );

  weave_dpath #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pixData(pixData),
    .rowAddr(rowAddr), .colAddr(colAddr), .wrData(wrData), .wrEn(wrEn)
  );
endmodule

// File: rtl/weave_checker.sv
module weave_checker #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pixData,
  input logic              pixValid,
  input logic              hRef,
  input logic              vRef,
  input logic [ROW_W-1:0]  rowAddr,
  input logic [COL_W-1:0]  colAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrEn,
  input logic              frameDone
);
  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!wrEn && !frameDone));

  assert_write_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> $past(pixValid));

  assert_write_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> wrData == $past(pixData));

  assert_line_start_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && $past(hRef) && !$past(hRef, 2)) |-> colAddr == '0);

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && $past(wrEn) && $past(hRef, 2) && $past(colAddr) != COL_MAX)
      |-> colAddr == $past(colAddr) + 1'b1);

  assert_col_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && $past(wrEn) && $past(hRef, 2) && $past(colAddr) == COL_MAX)
      |-> colAddr == COL_MAX);

  assert_parity_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && $past(wrEn)) |-> rowAddr[0] == $past(rowAddr[0]));

  assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  assert_frame_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> ($past(vRef) && !$past(vRef, 2)));
endmodule

bind field_weave_writer weave_checker #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pixData(pixData), .pixValid(pixValid), .hRef(hRef),
  .vRef(vRef), .rowAddr(rowAddr), .colAddr(colAddr), .wrData(wrData),
  .wrEn(wrEn), .frameDone(frameDone)
);

// File: tb/field_weave_writer_tb.sv
`timescale 1ns/1ps
module field_weave_writer_tb;
  localparam int DATA_W = 16;
  localparam int COL_W  = 10;
  localparam int ROW_W  = 10;
  localparam int COL_LIM = (1 << COL_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] pixData = '0;
  logic pixValid = 1'b0, hRef = 1'b0, vRef = 1'b0, oddFlag = 1'b0;
  logic [ROW_W-1:0]  rowAddr;
  logic [COL_W-1:0]  colAddr;
  logic [DATA_W-1:0] wrData;
  logic wrEn, frameDone;

  int nTests = 0;
  int nFail  = 0;

  // expected-state bookkeeping derived from the requirements
  int tbCol, tbLine;
  bit tbOdd, tbOddDone, tbFieldPix, tbLinePix, tbFirstInField;

  always #4 clk = ~clk;

  field_weave_writer #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pixData(pixData), .pixValid(pixValid),
    .hRef(hRef), .vRef(vRef), .oddFlag(oddFlag), .rowAddr(rowAddr),
    .colAddr(colAddr), .wrData(wrData), .wrEn(wrEn), .frameDone(frameDone)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCol(int c);
    return (c > COL_LIM) ? COL_LIM : c;
  endfunction

  function automatic int expRow(int line, bit odd);
    return 2 * line + int'(odd);
  endfunction

  // one horizontal line; pct = chance of a valid pixel per cycle
  task automatic doLine(int len, int pct, bit noisy);
    tbCol = 0;
    tbLinePix = 0;
    for (int i = 0; i < len; i++) begin
      bit v;
      v = (($urandom % 100) < pct);
      hRef = 1'b1;
      pixValid = v;
      pixData = DATA_W'($urandom);
      if (noisy) oddFlag = 1'($urandom);
      tick();
      if (v) begin
        chk("R2 wrEn", 32'(wrEn), 32'd1);
        chk("R2 wrData", 32'(wrData), 32'(pixData));
        chk(tbCol >= COL_LIM ? "R4 colAddr" : "R3 colAddr", 32'(colAddr), 32'(expCol(tbCol)));
        chk(noisy ? "R9 rowAddr" : "R7 rowAddr", 32'(rowAddr), 32'(expRow(tbLine, tbOdd)));
        if (tbFirstInField) begin
          chk("R6 first row of field", 32'(rowAddr), 32'(tbOdd));
          tbFirstInField = 0;
        end
        tbCol++;
        tbLinePix = 1;
        tbFieldPix = 1;
      end else begin
        chk("R2 no write", 32'(wrEn), 32'd0);
      end
    end
    hRef = 1'b0;
    pixValid = 1'b0;
    tick();
    chk("R2 idle after line", 32'(wrEn), 32'd0);
    tick();
    if (tbLinePix) tbLine++;   // R5: only lines with pixels consume a row
  endtask

  // field start sequence, then lines; dropAt selects a line with no pixels
  task automatic doField(bit odd, int nLines, int lenMin, int lenMax, int pct,
                         bit noisy, int dropAt);
    bit expDone;
    vRef = 1'b1;
    oddFlag = 1'($urandom);
    tick();
    expDone = (!tbOdd && tbOddDone && tbFieldPix);
    if (expDone) tbOddDone = 0;
    else if (tbOdd && tbFieldPix) tbOddDone = 1;
    tbFieldPix = 0;
    chk("R8 frameDone at field end", 32'(frameDone), 32'(expDone));
    oddFlag = ~odd;
    tick();
    chk("R8 frameDone one cycle", 32'(frameDone), 32'd0);
    vRef = 1'b0;
    oddFlag = odd;    // value at the falling edge is the parity (R7)
    tick();
    tbOdd = odd;
    tbLine = 0;
    tbFirstInField = 1;
    for (int l = 0; l < nLines; l++) begin
      int len;
      len = lenMin + int'($urandom % (lenMax - lenMin + 1));
      doLine(len, (l == dropAt) ? 0 : pct, noisy);
      if (l == dropAt) chk("R5 dropped line keeps row", 32'(tbLinePix), 32'd0);
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tbCol = 0; tbLine = 0; tbOdd = 0; tbOddDone = 0; tbFieldPix = 0;
    tbLinePix = 0; tbFirstInField = 0;
    repeat (3) tick();
    chk("R1 wrEn in reset", 32'(wrEn), 32'd0);
    chk("R1 frameDone in reset", 32'(frameDone), 32'd0);
    chk("R1 rowAddr in reset", 32'(rowAddr), 32'd0);
    chk("R1 colAddr in reset", 32'(colAddr), 32'd0);
    rst_n = 1'b1;
    tick();

    // directed: odd then even field, with a dropped line and oddFlag noise
    doField(1'b1, 4, 12, 30, 70, 1'b0, 2);
    doField(1'b0, 4, 12, 30, 70, 1'b1, 1);
    // frame completes here; odd field with a saturating line
    doField(1'b1, 0, 1, 1, 100, 1'b0, -1);
    doLine(1030, 100, 1'b0);
    // empty even field: no completion expected at its end
    doField(1'b0, 2, 8, 8, 0, 1'b0, -1);
    doField(1'b0, 3, 8, 20, 90, 1'b0, -1);
    // two odd fields in a row, then even
    doField(1'b1, 2, 8, 20, 100, 1'b0, -1);
    doField(1'b1, 2, 8, 20, 60, 1'b1, -1);
    doField(1'b0, 3, 8, 20, 50, 1'b0, 0);

    // constrained random fields
    for (int f = 0; f < 8; f++) begin
      doField(1'($urandom), 2 + int'($urandom % 4), 6, 40,
              40 + int'($urandom % 61), 1'($urandom), int'($urandom % 6));
    end
    doField(1'b0, 0, 1, 1, 0, 1'b0, -1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule